// File: doc/BRIEF.md
# Flash Instruction Prefetch Buffer Controller

This block sits between the instruction-fetch port of a CPU and a slow flash array made of two banks. It keeps two 256-bit line buffers. A fetch whose line is already in a buffer is answered in the same cycle. A fetch that misses reads one whole line from both banks at once, after a programmable number of wait states, and places it in the least recently used buffer.

While the CPU runs straight through a line, the block looks ahead. When the CPU accepts a fixed word of the current line, the block fetches the next sequential line into the other buffer, so that a sequential crossing into that line can proceed without a stall.

A line fetch may only begin while neither the data port nor a program/erase operation is using the banks. An auto-fill that is running or queued always completes before a new miss is fetched. The CPU side is a request/ready handshake: the CPU holds its request and word address until ready is seen high at a clock edge.

Top module: `ifetch_prefetch`

## Requirements
- R1: A request whose line is held in a valid buffer gets `cpu_rdy` high in the same cycle, with the addressed word on `cpu_rdata`. The word address splits into a line number (upper bits) and a word index (low 3 bits).
- R2: A fill brings in the complete 8-word line in a single access. `fl_bank0_data` supplies words 0 to 3 and `fl_bank1_data` supplies words 4 to 7, with word k of a bank at bits [32k+31:32k]. The word returned is the word at the requested address.
- R3: A line fetch holds `fl_rd` high for `wait_states`+1 cycles and writes the line in the last of those cycles. The word is returned one cycle later. A miss that meets idle banks therefore stalls for `wait_states`+2 cycles.
- R4: A fetch begins only in a cycle in which `dport_busy` and `pe_busy` are both low. Each cycle either input holds a pending miss adds one stall cycle.
- R5: Every fill replaces the least recently used buffer. A completed hit or a fill makes that buffer the most recently used, and a fill wins when both happen in the same cycle. After reset, buffer 0 is the first to be replaced.
- R6: When a hit completes on word index `TRIG_WORD` (3), the next line (line+1) is fetched into the other buffer, starting at that clock edge. This is skipped if that line is already held or already being fetched. Word 0 of the next line then stalls for max(0, `wait_states`+`TRIG_WORD`+2-8) cycles.
- R7: A request for the line that is currently being filled stalls and does not start a second fetch. It is served in the cycle after the line is written.
- R8: A miss that arrives while an auto-fill is running waits until the auto-fill completes, and its own fetch starts in the following cycle. A miss that arrives in the first cycle of the auto-fill stalls for 2*`wait_states`+3 cycles.
- R9: Asserting `rst_n` (active low, asynchronous) invalidates both buffers, aborts any fetch in progress (`fl_rd` low at once), clears any queued auto-fill and holds `cpu_rdy` low.
- R10: `cpu_rdy` is high only while `cpu_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_states | input | 4 | Extra flash cycles per line fetch |
| cpu_req | input | 1 | Instruction fetch request |
| cpu_addr | input | 20 | Word address of the fetch |
| cpu_rdy | output | 1 | Fetch completes at this clock edge |
| cpu_rdata | output | 32 | Fetched instruction word |
| dport_busy | input | 1 | Data port is using the flash banks |
| pe_busy | input | 1 | Program/erase is using the flash banks |
| fl_rd | output | 1 | Line read in progress on both banks |
| fl_line | output | 17 | Line number being read |
| fl_bank0_data | input | 128 | Words 0 to 3 of the line from bank 0 |
| fl_bank1_data | input | 128 | Words 4 to 7 of the line from bank 1 |

## Verification
A hit is due in the same cycle as its request. A miss is due `wait_states`+2 cycles later, plus one cycle for each cycle the banks were busy. A miss queued behind an auto-fill that has just started is due after 2*`wait_states`+3 cycles. Word 0 of a line fetched ahead is due after max(0, `wait_states`-3) cycles. The bench drives each request at a falling edge, samples `cpu_rdy` 1 ns later in every cycle, counts the low cycles and compares that count with the value the formula gives. Each test sets the buffer contents and LRU order through earlier fetches, so that every expected count follows from the requirements.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  typedef enum logic {
    FS_IDLE  = 1'b0,
    FS_FETCH = 1'b1
  } fill_state_e;
endpackage

// File: rtl/pfb_line_store.sv
// Two line buffers with tag/valid, a CPU lookup port and a lookahead query port.
module pfb_line_store #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 8,
  parameter int TAG_W  = 17
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         wr_sel,
  input  logic [TAG_W-1:0]             wr_tag,
  input  logic [WORD_W*WORDS-1:0]      wr_line,
  input  logic                         inv_en,
  input  logic                         inv_sel,
  input  logic [TAG_W-1:0]             rd_tag,
  input  logic [$clog2(WORDS)-1:0]     rd_off,
  input  logic [TAG_W-1:0]             q_tag,
  output logic                         hit,
  output logic                         hit_sel,
  output logic [WORD_W-1:0]            rd_word,
  output logic                         q_hit
);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int LINE_W = WORD_W * WORDS;
  localparam int NBUF   = 2;

  logic [NBUF-1:0]   vld;
  logic [NBUF-1:0]   match;
  logic [NBUF-1:0]   q_match;
  logic [TAG_W-1:0]  tag_a [NBUF];
  logic [LINE_W-1:0] dat_a [NBUF];
  logic [LINE_W-1:0] sel_line;

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    localparam logic ME = 1'(b);
    logic              vld_q;
    logic [TAG_W-1:0]  tag_q;
    logic [LINE_W-1:0] dat_q;
    logic              wr_me;
    logic              inv_me;

    assign wr_me  = wr_en && (wr_sel == ME);
    assign inv_me = inv_en && (inv_sel == ME);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        tag_q <= '0;
      end else begin
        if (wr_me) begin
          vld_q <= 1'b1;
          tag_q <= wr_tag;
        end
        if (inv_me) begin
          vld_q <= 1'b0;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (wr_me) begin
        dat_q <= wr_line;
      end
    end

    assign vld[b]     = vld_q;
    assign tag_a[b]   = tag_q;
    assign dat_a[b]   = dat_q;
    assign match[b]   = vld_q && (tag_q == rd_tag);
    assign q_match[b] = vld_q && (tag_q == q_tag);
  end

  always_comb begin
    hit      = |match;
    hit_sel  = match[1];
    q_hit    = |q_match;
    sel_line = dat_a[hit_sel];
    rd_word  = sel_line[rd_off*WORD_W +: WORD_W];
  end

  logic unused_ok;
  assign unused_ok = ^{vld, tag_a[0], tag_a[1], OFF_W[0]};
endmodule

// File: rtl/pfb_lru.sv
// One-bit recency tracker for the two buffers; fill touches win over hit touches.
module pfb_lru (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_touch,
  input  logic hit_sel,
  input  logic fill_touch,
  input  logic fill_sel,
  output logic lru
);
  logic lru_q, lru_d, lru_en;

  always_comb begin
    lru_en = fill_touch || hit_touch;
    lru_d  = fill_touch ? ~fill_sel : ~hit_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lru_q <= 1'b0;
    end else if (lru_en) begin
      lru_q <= lru_d;
    end
  end

  assign lru = lru_q;
endmodule

// File: rtl/pfb_fill_ctrl.sv
// Fill sequencer: miss / lookahead arbitration, bank-busy gating, wait-state count.
module pfb_fill_ctrl
  import pfb_pkg::*;
#(
  parameter int TAG_W = 17,
  parameter int WS_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WS_W-1:0]  wait_states,
  input  logic             banks_busy,
  input  logic             miss_req,
  input  logic [TAG_W-1:0] miss_tag,
  input  logic             af_new,
  input  logic [TAG_W-1:0] af_tag,
  input  logic             af_present,
  input  logic             hit_done,
  input  logic             hit_sel,
  input  logic             lru,
  output logic             fl_rd,
  output logic [TAG_W-1:0] fl_line,
  output logic             wr_en,
  output logic             wr_sel,
  output logic [TAG_W-1:0] wr_tag,
  output logic             inv_en,
  output logic             inv_sel
);
  fill_state_e      state_q, state_d;
  logic [WS_W-1:0]  cnt_q, cnt_d;
  logic [TAG_W-1:0] cur_tag_q, cur_tag_d;
  logic             cur_sel_q, cur_sel_d;
  logic             pend_q, pend_d;
  logic [TAG_W-1:0] pend_tag_q, pend_tag_d;

  logic             idle, can_go, go_pend, go_new, go_miss, start, last;
  logic             af_dup, af_want, start_sel;
  logic [TAG_W-1:0] start_tag;

  always_comb begin
    idle      = (state_q == FS_IDLE);
    af_dup    = (!idle && (cur_tag_q == af_tag)) || (pend_q && (pend_tag_q == af_tag));
    af_want   = af_new && !af_present && !af_dup;
    can_go    = idle && !banks_busy;
    go_pend   = can_go && pend_q;
    go_new    = can_go && !pend_q && af_want;
    go_miss   = can_go && !pend_q && !af_want && miss_req;
    start     = go_pend || go_new || go_miss;
    start_tag = go_pend ? pend_tag_q : (go_new ? af_tag : miss_tag);
    start_sel = hit_done ? ~hit_sel : lru;
    last      = !idle && (cnt_q == '0);

    state_d   = state_q;
    cnt_d     = cnt_q;
    cur_tag_d = cur_tag_q;
    cur_sel_d = cur_sel_q;
    if (start) begin
      state_d   = FS_FETCH;
      cnt_d     = wait_states;
      cur_tag_d = start_tag;
      cur_sel_d = start_sel;
    end else if (!idle) begin
      if (last) begin
        state_d = FS_IDLE;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end

    pend_d     = pend_q && !go_pend;
    pend_tag_d = pend_tag_q;
    if (af_want && !go_new) begin
      pend_d     = 1'b1;
      pend_tag_d = af_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= FS_IDLE;
      cnt_q      <= '0;
      cur_tag_q  <= '0;
      cur_sel_q  <= 1'b0;
      pend_q     <= 1'b0;
      pend_tag_q <= '0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      cur_tag_q  <= cur_tag_d;
      cur_sel_q  <= cur_sel_d;
      pend_q     <= pend_d;
      pend_tag_q <= pend_tag_d;
    end
  end

  always_comb begin
    fl_rd   = !idle;
    fl_line = cur_tag_q;
    wr_en   = last;
    wr_sel  = cur_sel_q;
    wr_tag  = cur_tag_q;
    inv_en  = start;
    inv_sel = start_sel;
  end
endmodule

// File: rtl/ifetch_prefetch.sv
// Top: instruction prefetch buffer controller in front of a two-bank flash.
module ifetch_prefetch #(
  parameter int AW        = 20,
  parameter int WORD_W    = 32,
  parameter int WORDS     = 8,
  parameter int WS_W      = 4,
  parameter int TRIG_WORD = 3
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [WS_W-1:0]                        wait_states,
  input  logic                                   cpu_req,
  input  logic [AW-1:0]                          cpu_addr,
  output logic                                   cpu_rdy,
  output logic [WORD_W-1:0]                      cpu_rdata,
  input  logic                                   dport_busy,
  input  logic                                   pe_busy,
  output logic                                   fl_rd,
  output logic [AW-$clog2(WORDS)-1:0]            fl_line,
  input  logic [WORD_W*WORDS/2-1:0]              fl_bank0_data,
  input  logic [WORD_W*WORDS/2-1:0]              fl_bank1_data
);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int TAG_W  = AW - OFF_W;
  localparam int LINE_W = WORD_W * WORDS;
  localparam logic [OFF_W-1:0] TRIG_OFF = OFF_W'(TRIG_WORD);
  localparam logic [TAG_W-1:0] ONE_LINE = TAG_W'(1);

  logic [TAG_W-1:0]  req_line;
  logic [OFF_W-1:0]  req_off;
  logic [TAG_W-1:0]  next_line;
  logic              hit, hit_sel, q_hit, hit_done;
  logic              af_new, miss_req, banks_busy;
  logic              fill_wr, fill_sel, inv_en, inv_sel, lru_buf;
  logic [TAG_W-1:0]  fill_tag;
  logic [LINE_W-1:0] fill_line;
  logic [WORD_W-1:0] rd_word;

  always_comb begin
    req_line   = cpu_addr[AW-1:OFF_W];
    req_off    = cpu_addr[OFF_W-1:0];
    next_line  = req_line + ONE_LINE;
    hit_done   = cpu_req && hit;
    af_new     = hit_done && (req_off == TRIG_OFF);
    miss_req   = cpu_req && !hit;
    banks_busy = dport_busy || pe_busy;
    fill_line  = {fl_bank1_data, fl_bank0_data};
  end

  pfb_line_store #(
    .WORD_W (WORD_W),
    .WORDS  (WORDS),
    .TAG_W  (TAG_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (fill_wr),
    .wr_sel  (fill_sel),
    .wr_tag  (fill_tag),
    .wr_line (fill_line),
    .inv_en  (inv_en),
    .inv_sel (inv_sel),
    .rd_tag  (req_line),
    .rd_off  (req_off),
    .q_tag   (next_line),
    .hit     (hit),
    .hit_sel (hit_sel),
    .rd_word (rd_word),
    .q_hit   (q_hit)
  );

  pfb_lru u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_touch  (hit_done),
    .hit_sel    (hit_sel),
    .fill_touch (fill_wr),
    .fill_sel   (fill_sel),
    .lru        (lru_buf)
  );

  pfb_fill_ctrl #(
    .TAG_W (TAG_W),
    .WS_W  (WS_W)
  ) u_fill (
    .clk         (clk),
    .rst_n       (rst_n),
    .wait_states (wait_states),
    .banks_busy  (banks_busy),
    .miss_req    (miss_req),
    .miss_tag    (req_line),
    .af_new      (af_new),
    .af_tag      (next_line),
    .af_present  (q_hit),
    .hit_done    (hit_done),
    .hit_sel     (hit_sel),
    .lru         (lru_buf),
    .fl_rd       (fl_rd),
    .fl_line     (fl_line),
    .wr_en       (fill_wr),
    .wr_sel      (fill_sel),
    .wr_tag      (fill_tag),
    .inv_en      (inv_en),
    .inv_sel     (inv_sel)
  );

  assign cpu_rdy   = hit_done;
  assign cpu_rdata = rd_word;
endmodule

// File: rtl/pfb_checker.sv
// Property checker attached to the prefetch controller.
module pfb_checker #(
  parameter int AW    = 20,
  parameter int WORDS = 8,
  parameter int WS_W  = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cpu_req,
  input logic                          cpu_rdy,
  input logic [AW-1:0]                 cpu_addr,
  input logic [WS_W-1:0]               wait_states,
  input logic                          dport_busy,
  input logic                          pe_busy,
  input logic                          fl_rd,
  input logic [AW-$clog2(WORDS)-1:0]   fl_line,
  input logic                          hit_done,
  input logic                          hit_sel,
  input logic                          fill_wr,
  input logic                          fill_sel,
  input logic                          lru_buf
);
  localparam int OFF_W = $clog2(WORDS);

  logic            rd_q;
  logic [WS_W-1:0] ws_q, ws_cap;
  logic [7:0]      run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      ws_q   <= '0;
      ws_cap <= '0;
      run    <= '0;
    end else begin
      rd_q <= fl_rd;
      ws_q <= wait_states;
      if (fl_rd && !rd_q) begin
        ws_cap <= ws_q;
      end
      run <= fl_rd ? run + 8'd1 : 8'd0;
    end
  end

  a_r10_rdy_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdy |-> cpu_req);

  a_r3_fetch_length: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q && !fl_rd) |-> (run == 8'(ws_cap) + 8'd1));

  a_r4_start_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_rd) |-> $past(!dport_busy && !pe_busy));

  a_r5_lru_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_done && !fill_wr) |=> (lru_buf == !$past(hit_sel)));

  a_r5_lru_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    fill_wr |=> (lru_buf == !$past(fill_sel)));

  a_r7_stall_on_fill_line: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_rd && cpu_req && (cpu_addr[AW-1:OFF_W] == fl_line)) |-> !cpu_rdy);
endmodule

bind ifetch_prefetch pfb_checker #(
  .AW    (AW),
  .WORDS (WORDS),
  .WS_W  (WS_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_req     (cpu_req),
  .cpu_rdy     (cpu_rdy),
  .cpu_addr    (cpu_addr),
  .wait_states (wait_states),
  .dport_busy  (dport_busy),
  .pe_busy     (pe_busy),
  .fl_rd       (fl_rd),
  .fl_line     (fl_line),
  .hit_done    (hit_done),
  .hit_sel     (hit_sel),
  .fill_wr     (fill_wr),
  .fill_sel    (fill_sel),
  .lru_buf     (lru_buf)
);

// File: tb/ifetch_prefetch_test.sv
module ifetch_prefetch_test;
  logic         clk;
  logic         rst_n;
  logic [3:0]   wait_states;
  logic         cpu_req;
  logic [19:0]  cpu_addr;
  logic         cpu_rdy;
  logic [31:0]  cpu_rdata;
  logic         dport_busy;
  logic         pe_busy;
  logic         fl_rd;
  logic [16:0]  fl_line;
  logic [127:0] fl_bank0_data;
  logic [127:0] fl_bank1_data;

  int tests;
  int fails;

  ifetch_prefetch uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .wait_states   (wait_states),
    .cpu_req       (cpu_req),
    .cpu_addr      (cpu_addr),
    .cpu_rdy       (cpu_rdy),
    .cpu_rdata     (cpu_rdata),
    .dport_busy    (dport_busy),
    .pe_busy       (pe_busy),
    .fl_rd         (fl_rd),
    .fl_line       (fl_line),
    .fl_bank0_data (fl_bank0_data),
    .fl_bank1_data (fl_bank1_data)
  );

  initial clk = 1'b0;
  always #5ns clk = ~clk;

  function automatic logic [31:0] wval(input logic [19:0] a);
    return (32'(a) * 32'h0100_0193) ^ 32'h5A5A_C3C3;
  endfunction

  function automatic logic [19:0] wa(input int line, input int w);
    return {17'(line), 3'(w)};
  endfunction

  // Flash stand-in: bank 0 holds words 0..3, bank 1 holds words 4..7.
  always_comb begin
    for (int k = 0; k < 4; k++) begin
      fl_bank0_data[k*32 +: 32] = wval({fl_line, 3'(k)});
      fl_bank1_data[k*32 +: 32] = wval({fl_line, 3'(k + 4)});
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic access(input logic [19:0] a, input int rel, input bit use_pe,
                        output int n, output logic [31:0] d);
    @(negedge clk);
    cpu_addr = a;
    cpu_req  = 1'b1;
    n = 0;
    d = '0;
    if (rel > 0) begin
      if (use_pe) pe_busy = 1'b1;
      else        dport_busy = 1'b1;
    end
    forever begin
      if (n >= rel) begin
        dport_busy = 1'b0;
        pe_busy    = 1'b0;
      end
      #1ns;
      if (cpu_rdy) begin
        d = cpu_rdata;
        break;
      end
      n++;
      if (n > 400) begin
        chk(1'b0, "R3", "access never completed", n, 0);
        break;
      end
      @(negedge clk);
    end
    @(posedge clk);
  endtask

  task automatic run(input int line, input int w, input int exp_n, input string rq);
    int n;
    logic [31:0] d;
    access(wa(line, w), 0, 1'b0, n, d);
    chk(n == exp_n, rq, $sformatf("stall cycles line %0d word %0d", line, w), n, exp_n);
    chk(d == wval(wa(line, w)), "R2", $sformatf("data line %0d word %0d", line, w),
        d, wval(wa(line, w)));
  endtask

  initial begin
    #1500us;
    tests++;
    fails++;
    $display("FAIL R3 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    logic [31:0] d;
    int seed;
    tests = 0;
    fails = 0;
    rst_n = 1'b0;
    cpu_req = 1'b0;
    cpu_addr = '0;
    wait_states = 4'd2;
    dport_busy = 1'b0;
    pe_busy = 1'b0;
    repeat (3) @(negedge clk);
    #1ns;
    chk(fl_rd == 1'b0, "R9", "fl_rd in reset", fl_rd, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1ns;
    chk(cpu_rdy == 1'b0, "R10", "rdy without request", cpu_rdy, 0);
    cpu_req = 1'b1;
    #1ns;
    chk(cpu_rdy == 1'b0, "R9", "rdy with empty buffers", cpu_rdy, 0);
    cpu_req = 1'b0;

    // R3 miss latency, R1 hits in the same line.
    wait_states = 4'd2;
    run(5, 1, 4, "R3");
    run(5, 6, 0, "R1");
    run(5, 2, 0, "R1");

    // R6 lookahead fill with ws=3: no stall at the line crossing.
    wait_states = 4'd3;
    run(10, 0, 5, "R3");
    for (int w = 1; w < 8; w++) run(10, w, 0, "R6");
    run(11, 0, 0, "R6");

    // R7 crossing into a line still being filled with ws=6: 3 stall cycles.
    wait_states = 4'd6;
    run(20, 0, 8, "R3");
    for (int w = 1; w < 8; w++) run(20, w, 0, "R1");
    run(21, 0, 3, "R7");

    // R8 miss behind an auto-fill, then R5 replacement order.
    wait_states = 4'd4;
    run(30, 0, 6, "R3");
    run(30, 3, 0, "R1");
    run(40, 2, 11, "R8");
    run(31, 0, 0, "R5");
    run(30, 0, 6, "R5");
    run(31, 1, 0, "R5");
    run(40, 0, 6, "R5");

    // R4 bank busy delays the fetch start.
    wait_states = 4'd2;
    access(wa(50, 0), 3, 1'b0, n, d);
    chk(n == 7, "R4", "stall with data port busy", n, 7);
    chk(d == wval(wa(50, 0)), "R2", "data after busy", d, wval(wa(50, 0)));
    access(wa(60, 1), 2, 1'b1, n, d);
    chk(n == 6, "R4", "stall with program/erase busy", n, 6);
    chk(d == wval(wa(60, 1)), "R2", "data after busy", d, wval(wa(60, 1)));

    // R9 reset during a fetch.
    wait_states = 4'd5;
    @(negedge clk);
    cpu_addr = wa(80, 0);
    cpu_req = 1'b1;
    repeat (3) @(negedge clk);
    chk(fl_rd == 1'b1, "R3", "fetch running before reset", fl_rd, 1);
    rst_n = 1'b0;
    cpu_req = 1'b0;
    #1ns;
    chk(fl_rd == 1'b0, "R9", "fetch aborted by reset", fl_rd, 0);
    chk(cpu_rdy == 1'b0, "R9", "rdy in reset", cpu_rdy, 0);
    @(negedge clk);
    rst_n = 1'b1;
    run(80, 0, 7, "R9");
    run(60, 1, 7, "R9");

    // Random phase with a fixed seed.
    seed = $urandom(32'h00C0_FFEE);
    for (int i = 0; i < 300; i++) begin
      int ln;
      int w;
      int rel;
      logic [19:0] a;
      ln = 100 + int'($urandom % 6);
      w  = int'($urandom % 8);
      rel = (($urandom % 4) == 0) ? 1 + int'($urandom % 2) : 0;
      @(negedge clk);
      wait_states = 4'($urandom % 5);
      a = wa(ln, w);
      access(a, rel, 1'b0, n, d);
      chk(d == wval(a), "R2", "random data", d, wval(a));
      chk(n <= 40, "R3", "random stall bound", n, 40);
      if (($urandom % 3) == 0) begin
        access(a, 0, 1'b0, n, d);
        chk(n == 0, "R1", "repeat access hits", n, 0);
        chk(d == wval(a), "R2", "repeat data", d, wval(a));
      end
    end

    @(negedge clk);
    cpu_req = 1'b0;
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule